// File: doc/BRIEF.md
# Multiplexed-Address Flash Host Sequencer

This block sits on the host side of a parallel byte-wide flash device whose address enters through a narrow, shared set of pins. A client hands it one read or write at a time over a valid/ready handshake. The request carries a 19-bit byte address and, for a write, one data byte. The sequencer splits the address into a low half and a high half. It presents the low half on the 11 shared pins and drops the row/column strobe, so the device latches the low half on that falling edge. It then presents the high half and raises the strobe, so the device latches it on that rising edge.

A write drives the byte onto the data lines and pulses the active-low write strobe, and the device captures the byte on the rising edge of that pulse. A read releases the data lines, pulls output enable low, and waits a programmable access time. It then captures the byte the device drives and raises output enable again. Either access ends with a one-cycle completion pulse. Every setup, hold, pulse and access width is a parameter counted in clock cycles.

The sequencer also has two housekeeping paths. One produces a timed low pulse on the device's reset pin when the client asks for it. The other synchronises the open-drain ready/busy line into a busy flag. Optionally, it holds off new requests while that flag is set. The data bus is split into an output value, an output enable and an input value, so that the surrounding logic or a model can build the tri-state pad.

Top module: `mux_flash_host`

## Requirements
- R1: After a request is accepted, `fl_addr` carries `req_addr[10:0]` for SETUP_CYC cycles while `fl_rc_n` is high. `fl_rc_n` then falls, and `fl_addr` keeps the same value for HOLD_CYC more cycles.
- R2: After the row phase, `fl_addr[7:0]` carries `req_addr[18:11]` and `fl_addr[10:8]` is zero, for SETUP_CYC cycles while `fl_rc_n` is low. `fl_rc_n` then rises, and the value is held for HOLD_CYC more cycles.
- R3: A write (`req_write`=1) holds `dq_oe`=1 with `dq_out` = the request byte for SETUP_CYC cycles before `fl_we_n` falls. `fl_we_n` stays low for exactly PULSE_CYC cycles. Data stays driven for HOLD_CYC cycles after `fl_we_n` rises.
- R4: A read (`req_write`=0) holds `fl_oe_n` low for exactly ACC_CYC cycles, with `fl_we_n` and `fl_rst_n` high throughout. `rd_data` takes the `dq_in` value present in the last of those cycles.
- R5: `dq_oe` is never 1 in a cycle where `fl_oe_n` is 0, and `fl_we_n` and `fl_oe_n` are never low together.
- R6: `busy` equals the inverse of `fl_rdy` after a SYNC_STAGES-flop synchroniser. With WAIT_RDY=1, `req_ready` is 0 whenever `busy` is 1, and a pending request starts only after the line goes high again.
- R7: When `rst_req` is 1 in idle, `fl_rst_n` goes low for exactly RST_CYC cycles and `req_ready` is 0 while `rst_req` is 1. `fl_rst_n` is high during every read and write.
- R8: Only one transaction is in flight. `req_ready` is 0 from acceptance until completion, and `done` is a single-cycle pulse per transaction.
- R9: In idle, including right after reset, `fl_rc_n`, `fl_we_n`, `fl_oe_n` and `fl_rst_n` are all 1 and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sequencer |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| rst_req | input | 1 | Ask for a device reset pulse |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Read result, valid with done |
| busy | output | 1 | Synchronised inverse of the ready/busy line |
| fl_addr | output | 11 | Shared row/column address pins |
| fl_rc_n | output | 1 | Row/column strobe (row on fall, column on rise) |
| fl_we_n | output | 1 | Active-low write strobe |
| fl_oe_n | output | 1 | Active-low output enable |
| fl_rst_n | output | 1 | Active-low device reset |
| dq_out | output | 8 | Data driven toward the device |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 8 | Data returned from the device |
| fl_rdy | input | 1 | Ready/busy line, low while the device is busy |

## Verification
A flash model in the bench latches the row on the falling strobe edge and the column on the rising edge, and stores a byte on each write-strobe rise. Unwritten cells return an address-derived pattern. A walking-one sweep over all 19 address bits, plus a strided 64-address sweep, therefore exposes a swapped half, a shifted column or a wrong edge as a wrong byte on read-back. Stray upper column bits are checked directly. The bench measures the write-pulse and reset-pulse widths, so an off-by-one counter shows up as a width mismatch. It also looks for bus contention at each output-enable fall. A busy line held low checks that the request is stalled rather than issued, and a stuck or doubled completion pulse is caught by checking the cycle after done.

// File: rtl/mfh_pkg.sv
package mfh_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ROW_SET,
        S_ROW_LAT,
        S_COL_SET,
        S_COL_LAT,
        S_WR_SET,
        S_WR_LOW,
        S_WR_HOLD,
        S_RD_ACC,
        S_RST_LOW
    } mfh_state_e;

    function automatic int unsigned mfh_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mfh_sync.sv
module mfh_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (STAGES <= 1) begin : g_single
            logic stg_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= RESET_VAL;
                else        stg_q <= din;
            end
            assign dout = stg_q;
        end else begin : g_chain
            logic [STAGES-1:0] stg_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= {STAGES{RESET_VAL}};
                else        stg_q <= {stg_q[STAGES-2:0], din};
            end
            assign dout = stg_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/mfh_phase_timer.sv
module mfh_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)               cnt_d = load_val;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/mfh_addr_split.sv
module mfh_addr_split #(
    parameter int ROW_W = 11,
    parameter int COL_W = 8
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    output logic [ROW_W-1:0]       row_pins,
    output logic [ROW_W-1:0]       col_pins
);
    localparam int PAD_W = ROW_W - COL_W;

    assign row_pins = addr[ROW_W-1:0];

    generate
        if (PAD_W > 0) begin : g_pad
            assign col_pins = {{PAD_W{1'b0}}, addr[ROW_W+COL_W-1:ROW_W]};
        end else begin : g_nopad
            assign col_pins = addr[ROW_W+COL_W-1:ROW_W];
        end
    endgenerate
endmodule

// File: rtl/mux_flash_host.sv
module mux_flash_host
    import mfh_pkg::*;
#(
    parameter int ROW_W       = 11,
    parameter int COL_W       = 8,
    parameter int DATA_W      = 8,
    parameter int SETUP_CYC   = 1,
    parameter int PULSE_CYC   = 2,
    parameter int HOLD_CYC    = 1,
    parameter int ACC_CYC     = 2,
    parameter int RST_CYC     = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit WAIT_RDY    = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic                   rst_req,
    output logic                   done,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   busy,
    output logic [ROW_W-1:0]       fl_addr,
    output logic                   fl_rc_n,
    output logic                   fl_we_n,
    output logic                   fl_oe_n,
    output logic                   fl_rst_n,
    output logic [DATA_W-1:0]      dq_out,
    output logic                   dq_oe,
    input  logic [DATA_W-1:0]      dq_in,
    input  logic                   fl_rdy
);
    localparam int ADDR_W  = ROW_W + COL_W;
    localparam int MAX_LEN = mfh_max(mfh_max(mfh_max(SETUP_CYC, PULSE_CYC),
                                             mfh_max(HOLD_CYC, ACC_CYC)), RST_CYC);
    localparam int CNT_W   = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_ACC   = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RST   = CNT_W'(RST_CYC - 1);

    typedef struct packed {
        mfh_state_e          st;
        logic                wr;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [ROW_W-1:0]    pins;
        logic                rc_n;
        logic                we_n;
        logic                oe_n;
        logic                frst_n;
        logic                dq_oe;
        logic [DATA_W-1:0]   dq_out;
        logic [DATA_W-1:0]   rd_data;
        logic                done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             rdy_sync;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;
    logic [ROW_W-1:0] row_pins;
    logic [ROW_W-1:0] col_pins;
    logic             accept;

    mfh_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_rdy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (fl_rdy),
        .dout  (rdy_sync)
    );

    mfh_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    mfh_addr_split #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_split (
        .addr     (ctl_q.addr),
        .row_pins (row_pins),
        .col_pins (col_pins)
    );

    assign busy      = ~rdy_sync;
    assign req_ready = (ctl_q.st == S_IDLE) && !rst_req && !(WAIT_RDY && busy);
    assign accept    = req_valid && req_ready;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;

        unique case (ctl_q.st)
            S_IDLE: begin
                if (rst_req) begin
                    ctl_d.frst_n = 1'b0;
                    ctl_d.st     = S_RST_LOW;
                    tmr_load     = 1'b1;
                    tmr_val      = LD_RST;
                end else if (accept) begin
                    ctl_d.wr    = req_write;
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.pins  = req_addr[ROW_W-1:0];
                    ctl_d.st    = S_ROW_SET;
                    tmr_load    = 1'b1;
                    tmr_val     = LD_SETUP;
                end
            end
            S_ROW_SET: begin
                if (tmr_exp) begin
                    ctl_d.rc_n = 1'b0;
                    ctl_d.st   = S_ROW_LAT;
                    tmr_load   = 1'b1;
                    tmr_val    = LD_HOLD;
                end
            end
            S_ROW_LAT: begin
                if (tmr_exp) begin
                    ctl_d.pins = col_pins;
                    ctl_d.st   = S_COL_SET;
                    tmr_load   = 1'b1;
                    tmr_val    = LD_SETUP;
                end
            end
            S_COL_SET: begin
                if (tmr_exp) begin
                    ctl_d.rc_n = 1'b1;
                    ctl_d.st   = S_COL_LAT;
                    tmr_load   = 1'b1;
                    tmr_val    = LD_HOLD;
                end
            end
            S_COL_LAT: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (ctl_q.wr) begin
                        ctl_d.dq_oe  = 1'b1;
                        ctl_d.dq_out = ctl_q.wdata;
                        ctl_d.st     = S_WR_SET;
                        tmr_val      = LD_SETUP;
                    end else begin
                        ctl_d.dq_oe  = 1'b0;
                        ctl_d.oe_n   = 1'b0;
                        ctl_d.st     = S_RD_ACC;
                        tmr_val      = LD_ACC;
                    end
                end
            end
            S_WR_SET: begin
                if (tmr_exp) begin
                    ctl_d.we_n = 1'b0;
                    ctl_d.st   = S_WR_LOW;
                    tmr_load   = 1'b1;
                    tmr_val    = LD_PULSE;
                end
            end
            S_WR_LOW: begin
                if (tmr_exp) begin
                    ctl_d.we_n = 1'b1;
                    ctl_d.st   = S_WR_HOLD;
                    tmr_load   = 1'b1;
                    tmr_val    = LD_HOLD;
                end
            end
            S_WR_HOLD: begin
                if (tmr_exp) begin
                    ctl_d.dq_oe = 1'b0;
                    ctl_d.done  = 1'b1;
                    ctl_d.st    = S_IDLE;
                end
            end
            S_RD_ACC: begin
                if (tmr_exp) begin
                    ctl_d.rd_data = dq_in;
                    ctl_d.oe_n    = 1'b1;
                    ctl_d.done    = 1'b1;
                    ctl_d.st      = S_IDLE;
                end
            end
            S_RST_LOW: begin
                if (tmr_exp) begin
                    ctl_d.frst_n = 1'b1;
                    ctl_d.st     = S_IDLE;
                end
            end
            default: begin
                ctl_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q         <= '0;
            ctl_q.st      <= S_IDLE;
            ctl_q.rc_n    <= 1'b1;
            ctl_q.we_n    <= 1'b1;
            ctl_q.oe_n    <= 1'b1;
            ctl_q.frst_n  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign fl_addr  = ctl_q.pins;
    assign fl_rc_n  = ctl_q.rc_n;
    assign fl_we_n  = ctl_q.we_n;
    assign fl_oe_n  = ctl_q.oe_n;
    assign fl_rst_n = ctl_q.frst_n;
    assign dq_out   = ctl_q.dq_out;
    assign dq_oe    = ctl_q.dq_oe;
    assign rd_data  = ctl_q.rd_data;
    assign done     = ctl_q.done;
endmodule

// File: rtl/mfh_checker.sv
module mfh_checker #(
    parameter int ROW_W    = 11,
    parameter int COL_W    = 8,
    parameter int DATA_W   = 8,
    parameter bit WAIT_RDY = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              busy,
    input logic              done,
    input logic [ROW_W-1:0]  fl_addr,
    input logic              fl_rc_n,
    input logic              fl_we_n,
    input logic              fl_oe_n,
    input logic              fl_rst_n,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe
);
    // Column phase: upper pins beyond the column width are zero at the latching edge.
    p_col_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_rc_n) |-> (fl_addr >> COL_W) == '0);

    // Write data driven and unchanged as the write strobe rises.
    p_wr_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (dq_oe && $stable(dq_out)));

    // Read: reset and write strobe stay high while output enable is low.
    p_rd_levels_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (fl_we_n && fl_rst_n));

    // No contention on the data bus.
    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_oe && !fl_oe_n));

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));

    // Busy line holds off new requests.
    p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (WAIT_RDY && busy) |-> !req_ready);

    // Reset pin high during a write strobe.
    p_rst_high_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> fl_rst_n);

    // Completion is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Idle levels while accepting.
    p_idle_levels_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fl_rc_n && fl_we_n && fl_oe_n && fl_rst_n && !dq_oe));
endmodule

bind mux_flash_host mfh_checker #(
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .DATA_W   (DATA_W),
    .WAIT_RDY (WAIT_RDY)
) u_mfh_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .fl_addr   (fl_addr),
    .fl_rc_n   (fl_rc_n),
    .fl_we_n   (fl_we_n),
    .fl_oe_n   (fl_oe_n),
    .fl_rst_n  (fl_rst_n),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
);

// File: tb/mux_flash_host_test.sv
`timescale 1ns/1ps
module mux_flash_host_test;
    localparam int T_SET = 2;
    localparam int T_PUL = 3;
    localparam int T_HLD = 1;
    localparam int T_ACC = 2;
    localparam int T_RST = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rst_req = 1'b0;
    logic        done;
    logic [7:0]  rd_data;
    logic        busy;
    logic [10:0] fl_addr;
    logic        fl_rc_n, fl_we_n, fl_oe_n, fl_rst_n;
    logic [7:0]  dq_out;
    logic        dq_oe;
    logic [7:0]  dq_in;
    logic        fl_rdy = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mux_flash_host #(
        .SETUP_CYC (T_SET),
        .PULSE_CYC (T_PUL),
        .HOLD_CYC  (T_HLD),
        .ACC_CYC   (T_ACC),
        .RST_CYC   (T_RST),
        .WAIT_RDY  (1'b1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rst_req(rst_req), .done(done), .rd_data(rd_data), .busy(busy),
        .fl_addr(fl_addr), .fl_rc_n(fl_rc_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
        .fl_rst_n(fl_rst_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .fl_rdy(fl_rdy)
    );

    // ---------------- flash device model ----------------
    logic [7:0]  flash_mem [logic [18:0]];
    logic [10:0] row_l = '0;
    logic [7:0]  col_l = '0;
    logic [7:0]  dq_model = '0;

    function automatic logic [7:0] pat(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
    endfunction

    always @(negedge fl_rc_n) row_l = fl_addr;
    always @(posedge fl_rc_n) col_l = fl_addr[7:0];
    always @(posedge fl_we_n) if (rst_n && fl_rst_n) flash_mem[{col_l, row_l}] = dq_out;
    always @(negedge fl_oe_n) begin
        if (flash_mem.exists({col_l, row_l})) dq_model = flash_mem[{col_l, row_l}];
        else                                  dq_model = pat({col_l, row_l});
    end
    assign dq_in = fl_oe_n ? 8'h00 : dq_model;

    // ---------------- shadow of expected contents ----------------
    logic [7:0] shadow [logic [18:0]];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- monitors ----------------
    int we_low = 0;
    int rst_low = 0;
    bit mon_on = 1'b0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (!fl_we_n) we_low++;
            else if (we_low != 0) begin
                check(we_low == T_PUL, "R3 write pulse width", we_low, T_PUL);
                we_low = 0;
            end
            if (!fl_rst_n) rst_low++;
        end
    end
    always @(negedge fl_oe_n) if (mon_on) begin
        check(!dq_oe, "R5 bus released at oe fall", dq_oe, 0);
        check(fl_rst_n && fl_we_n, "R4 we/rst high during read", {fl_rst_n, fl_we_n}, 3);
    end
    always @(posedge fl_rc_n) if (mon_on)
        check(fl_addr[10:8] == 3'b000, "R2 upper column pins zero", fl_addr[10:8], 0);
    always @(negedge fl_we_n) if (mon_on)
        check(fl_rst_n && dq_oe, "R7 rst high and data driven at write", {fl_rst_n, dq_oe}, 3);

    // ---------------- transaction tasks ----------------
    task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d,
                         output logic [7:0] rd);
        int guard;
        req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
        guard = 0;
        while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
        @(negedge clk);
        req_valid = 1'b0;
        if (a[2:0] == 3'b000)
            check(!req_ready, "R8 no second request in flight", req_ready, 0);
        guard = 0;
        while (!done && guard < 1000) begin @(negedge clk); guard++; end
        rd = rd_data;
        if (a[3:0] == 4'h0)
            check(fl_rc_n && fl_we_n && fl_oe_n && !dq_oe, "R9 idle levels after done",
                  {fl_rc_n, fl_we_n, fl_oe_n, dq_oe}, 4'b1110);
        @(negedge clk);
        if (a[1:0] == 2'b00) check(!done, "R8 done single pulse", done, 0);
    endtask

    task automatic do_write(input logic [18:0] a, input logic [7:0] d);
        logic [7:0] unused;
        issue(1'b1, a, d, unused);
        shadow[a] = d;
    endtask

    task automatic do_read(input logic [18:0] a, input string req);
        logic [7:0] got, exp;
        issue(1'b0, a, 8'h00, got);
        exp = shadow.exists(a) ? shadow[a] : pat(a);
        check(got == exp, req, got, exp);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(fl_rc_n && fl_we_n && fl_oe_n && fl_rst_n && !dq_oe && !done,
              "R9 reset levels", {fl_rc_n, fl_we_n, fl_oe_n, fl_rst_n, dq_oe, done}, 6'b111100);
        check(req_ready && !busy, "R8 ready after reset", {req_ready, busy}, 2'b10);
        mon_on = 1'b1;

        // R1/R2 walking-one sweep across all address bits: read pattern, write, read back
        for (int b = 0; b < 19; b++) begin
            do_read(19'(1) << b, "R1 R2 R4 pattern read walking one");
            do_write(19'(1) << b, 8'((b * 37 + 1) & 8'hFF));
            do_read(19'(1) << b, "R3 read back walking one");
        end
        do_write(19'h7FFFF, 8'hC3);
        do_read(19'h7FFFF, "R2 all-ones address");
        do_read(19'h00000, "R1 zero address");

        // strided sweep: 64 writes then 64 reads
        for (int i = 0; i < 64; i++)
            do_write(19'((i * 8191 + 5) & 19'h7FFFF), 8'((i * 29) ^ 8'hA5));
        for (int i = 0; i < 64; i++)
            do_read(19'((i * 8191 + 5) & 19'h7FFFF), "R3 R4 strided read back");

        // R6 busy hold-off
        fl_rdy = 1'b0;
        repeat (3) @(negedge clk);
        check(busy, "R6 busy follows line", busy, 1);
        check(!req_ready, "R6 ready withheld while busy", req_ready, 0);
        req_write = 1'b0; req_addr = 19'h12345; req_valid = 1'b1;
        repeat (6) @(negedge clk);
        check(fl_rc_n && fl_oe_n && !done, "R6 no access while busy",
              {fl_rc_n, fl_oe_n, done}, 3'b110);
        fl_rdy = 1'b1;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && req_ready, "R6 released", {busy, req_ready}, 2'b01);
        do_read(19'h12345, "R6 read after release");

        // R7 reset pulse
        rst_req = 1'b1;
        #1;
        check(!req_ready, "R7 ready low with rst_req", req_ready, 0);
        @(negedge clk);
        rst_req = 1'b0;
        rst_low = 0;
        repeat (T_RST + 4) @(negedge clk);
        check(rst_low == T_RST, "R7 reset pulse width", rst_low, T_RST);
        check(fl_rst_n && req_ready, "R7 back to idle", {fl_rst_n, req_ready}, 2'b11);
        do_read(19'h7FFFF, "R7 access after reset pulse");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule